// File: doc/BRIEF.md
# Execute-Stage ALU and Condition Codes

This block is the execute stage of a single-cycle 32-bit processor. Each cycle it takes the decoded instruction class and function field, together with two register operands and an instruction constant. It picks the second ALU operand for that instruction class and produces the result word combinationally. The first operand is always the second register value. The second operand is a register value, the constant, or a fixed stack adjustment of plus or minus four.

A three-bit flag register holds the zero, sign and signed-overflow codes. It loads on the rising clock edge, and only for arithmetic/logic instructions. A combinational condition output is derived from the stored flags and the function field. The next-PC logic uses it for conditional jumps, and the write-back logic uses it for conditional moves. The reset input clears asynchronously. Its release is resynchronised to the clock, so the flags begin to load on the third rising edge after release.

Top module: `exu_top`

## Requirements
- R1: Operand A is `val_a` when `icode` is 2 (register move) or 6 (arithmetic/logic). It is `val_c` when `icode` is 3, 4 or 5 (immediate move, store, load).
- R2: When `icode` is 8 (call) or 0xA (push), `val_e` = `val_b` - 4. When `icode` is 9 (return) or 0xB (pop), `val_e` = `val_b` + 4 (modulo 2^32).
- R3: For `icode` 6 the operation is chosen by `ifun[1:0]`: 0 gives B+A, 1 gives B-A, 2 gives B AND A, 3 gives B XOR A. Every other `icode` adds, whatever `ifun` holds.
- R4: For every other `icode` (0, 1, 7 and 0xC-0xF), operand A is zero, so `val_e` = `val_b`.
- R5: The flags load only at a rising clock edge where `icode` is 6. At every other edge they keep their value.
- R6: After a load, zero is set exactly when the result was 0, and sign equals bit 31 of the result.
- R7: After a load, overflow is set on signed overflow of an add or subtract. It is cleared after an AND or XOR.
- R8: `cnd` is a combinational function of `ifun` and the stored flags (Z, S, O), where S^O means S XOR O. The encodings are: 0 always true; 1 (S^O)|Z; 2 S^O; 3 Z; 4 !Z; 5 !(S^O); 6 !(S^O)&!Z. Any `ifun` of 7 or above gives 0.
- R9: While `rst_n` is low the flags are zero=1, sign=0, overflow=0, and this takes effect at once without a clock edge. After `rst_n` rises, the first load can happen no earlier than the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| icode | input | 4 | Instruction class |
| ifun | input | 4 | Function / condition field |
| val_a | input | 32 | First register operand |
| val_b | input | 32 | Second register operand (ALU input B) |
| val_c | input | 32 | Instruction constant |
| val_e | output | 32 | ALU result |
| cnd | output | 1 | Condition outcome from stored flags |

## Verification
The flags are the only state, and they can be seen only through `cnd`. Any corruption of them therefore appears in the cycle after the load edge, as a wrong condition outcome for some encoding. The bench decodes each flag pattern through several encodings, such as eq, lt and gt, so that a single flipped bit changes at least one of them. A load on a non-arithmetic instruction, or a stale overflow bit after a logic operation, appears one cycle later in the same way. A reset synchroniser that is too short or too long shifts the first flag change by one edge.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam logic [3:0] OPC_HALT  = 4'h0;
  localparam logic [3:0] OPC_NOP   = 4'h1;
  localparam logic [3:0] OPC_RRMOV = 4'h2;
  localparam logic [3:0] OPC_IRMOV = 4'h3;
  localparam logic [3:0] OPC_STORE = 4'h4;
  localparam logic [3:0] OPC_LOAD  = 4'h5;
  localparam logic [3:0] OPC_ARITH = 4'h6;
  localparam logic [3:0] OPC_JUMP  = 4'h7;
  localparam logic [3:0] OPC_CALL  = 4'h8;
  localparam logic [3:0] OPC_RET   = 4'h9;
  localparam logic [3:0] OPC_PUSH  = 4'hA;
  localparam logic [3:0] OPC_POP   = 4'hB;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    BR_ALWAYS = 4'd0,
    BR_LE     = 4'd1,
    BR_LT     = 4'd2,
    BR_EQ     = 4'd3,
    BR_NE     = 4'd4,
    BR_GE     = 4'd5,
    BR_GT     = 4'd6
  } br_cond_e;

  typedef enum logic [1:0] {
    SELA_ZERO,
    SELA_REG,
    SELA_CONST,
    SELA_STACK
  } opa_sel_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_t;

  localparam cc_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exu_opnd_sel.sv
module exu_opnd_sel
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   icode,
  input  logic [1:0]   fn_field,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_c,
  output logic [W-1:0] opnd_a,
  output alu_fn_e      alu_fn,
  output logic         is_arith
);

  localparam logic [W-1:0] STACK_INC = W'(4);
  localparam logic [W-1:0] STACK_DEC = ~STACK_INC + W'(1);

  opa_sel_e sel;
  logic     stack_up;

  always_comb begin
    sel      = SELA_ZERO;
    stack_up = 1'b0;
    case (icode)
      OPC_RRMOV, OPC_ARITH:           sel = SELA_REG;
      OPC_IRMOV, OPC_STORE, OPC_LOAD: sel = SELA_CONST;
      OPC_CALL,  OPC_PUSH:            sel = SELA_STACK;
      OPC_RET,   OPC_POP: begin
        sel      = SELA_STACK;
        stack_up = 1'b1;
      end
      default:                        sel = SELA_ZERO;
    endcase
  end

  always_comb begin
    case (sel)
      SELA_REG:   opnd_a = val_a;
      SELA_CONST: opnd_a = val_c;
      SELA_STACK: opnd_a = stack_up ? STACK_INC : STACK_DEC;
      default:    opnd_a = '0;
    endcase
  end

  assign is_arith = (icode == OPC_ARITH);
  assign alu_fn   = is_arith ? alu_fn_e'(fn_field) : FN_ADD;

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  alu_fn_e      alu_fn,
  output logic [W-1:0] result,
  output cc_t          flags
);

  localparam int MSB = W - 1;

  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic         add_ovf;
  logic         sub_ovf;

  assign sum  = opnd_b + opnd_a;
  assign diff = opnd_b - opnd_a;

  // Signed overflow: add when equal-signed inputs give a differently-signed
  // sum; subtract B-A when the inputs differ in sign and the result sign
  // departs from B.
  assign add_ovf = (opnd_a[MSB] == opnd_b[MSB]) && (sum[MSB]  != opnd_b[MSB]);
  assign sub_ovf = (opnd_a[MSB] != opnd_b[MSB]) && (diff[MSB] != opnd_b[MSB]);

  always_comb begin
    case (alu_fn)
      FN_ADD:  result = sum;
      FN_SUB:  result = diff;
      FN_AND:  result = opnd_b & opnd_a;
      default: result = opnd_b ^ opnd_a;
    endcase
  end

  always_comb begin
    flags.zf = (result == '0);
    flags.sf = result[MSB];
    case (alu_fn)
      FN_ADD:  flags.of = add_ovf;
      FN_SUB:  flags.of = sub_ovf;
      default: flags.of = 1'b0;
    endcase
  end

endmodule

// File: rtl/exu_ccr.sv
module exu_ccr
  import exu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  cc_t  cc_d,
  output cc_t  cc_q,
  output logic srst_n
);

  localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SS-1:0] sync_q;
  cc_t           cc_nxt;

  // Reset synchroniser: asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SS-2:0], 1'b1};
  end

  assign srst_n = sync_q[SS-1];

  always_comb begin
    cc_nxt = cc_q;
    if (load_en) cc_nxt = cc_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cc_q <= CC_RESET;
    else         cc_q <= cc_nxt;
  end

endmodule

// File: rtl/exu_cond.sv
module exu_cond
  import exu_pkg::*;
(
  input  cc_t        cc,
  input  logic [3:0] cond_sel,
  output logic       cnd
);

  logic less;

  assign less = cc.sf ^ cc.of;

  always_comb begin
    case (cond_sel)
      BR_ALWAYS: cnd = 1'b1;
      BR_LE:     cnd = less | cc.zf;
      BR_LT:     cnd = less;
      BR_EQ:     cnd = cc.zf;
      BR_NE:     cnd = ~cc.zf;
      BR_GE:     cnd = ~less;
      BR_GT:     cnd = ~less & ~cc.zf;
      default:   cnd = 1'b0;
    endcase
  end

endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   icode,
  input  logic [3:0]   ifun,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic [W-1:0] val_c,
  output logic [W-1:0] val_e,
  output logic         cnd
);

  logic [W-1:0] opnd_a;
  alu_fn_e      alu_fn;
  logic         is_arith;
  cc_t          cc_d;
  cc_t          cc_q;
  logic         srst_n;

  exu_opnd_sel #(.W(W)) u_sel (
    .icode    (icode),
    .fn_field (ifun[1:0]),
    .val_a    (val_a),
    .val_c    (val_c),
    .opnd_a   (opnd_a),
    .alu_fn   (alu_fn),
    .is_arith (is_arith)
  );

  exu_alu #(.W(W)) u_alu (
    .opnd_a (opnd_a),
    .opnd_b (val_b),
    .alu_fn (alu_fn),
    .result (val_e),
    .flags  (cc_d)
  );

  exu_ccr #(.SYNC_STAGES(2)) u_ccr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (is_arith),
    .cc_d    (cc_d),
    .cc_q    (cc_q),
    .srst_n  (srst_n)
  );

  exu_cond u_cond (
    .cc       (cc_q),
    .cond_sel (ifun),
    .cnd      (cnd)
  );

endmodule

// File: rtl/exu_chk.sv
module exu_chk
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         srst_n,
  input logic [3:0]   icode,
  input logic [3:0]   ifun,
  input logic [W-1:0] val_b,
  input logic [W-1:0] val_e,
  input logic         cnd,
  input cc_t          cc
);

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (icode != OPC_ARITH) |=> $stable(cc)); // R5

  AST_CC_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (icode == OPC_ARITH) |=> (cc.zf == ($past(val_e) == '0))); // R6

  AST_CC_SIGN: assert property (@(posedge clk) disable iff (!srst_n)
    (icode == OPC_ARITH) |=> (cc.sf == $past(val_e[W-1]))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!srst_n)
    (icode == OPC_ARITH && ifun[1]) |=> !cc.of); // R7

  AST_STACK_UP: assert property (@(posedge clk) disable iff (!srst_n)
    (icode == OPC_RET || icode == OPC_POP) |-> (val_e == val_b + W'(4))); // R2

  AST_CND_EQ: assert property (@(posedge clk) disable iff (!srst_n)
    (ifun == 4'd3) |-> (cnd == cc.zf)); // R8

  AST_CND_UNDEF: assert property (@(posedge clk) disable iff (!srst_n)
    (ifun > 4'd6) |-> !cnd); // R8

endmodule

bind exu_top exu_chk #(.W(W)) u_chk (
  .clk    (clk),
  .srst_n (srst_n),
  .icode  (icode),
  .ifun   (ifun),
  .val_b  (val_b),
  .val_e  (val_e),
  .cnd    (cnd),
  .cc     (cc_q)
);

// File: tb/sim_exu_top.sv
`timescale 1ns/1ps
module sim_exu_top;

  logic        clk;
  logic        rst_n;
  logic [3:0]  icode;
  logic [3:0]  ifun;
  logic [31:0] val_a;
  logic [31:0] val_b;
  logic [31:0] val_c;
  logic [31:0] val_e;
  logic        cnd;

  int n_run;
  int n_fail;
  bit done;

  exu_top #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .icode(icode), .ifun(ifun),
    .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .val_e(val_e), .cnd(cnd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req, icode, ifun, a, b, c, expected val_e}
  localparam int NV = 18;
  localparam logic [139:0] VECS [NV] = '{
    {4'd1, 4'h2, 4'h0, 32'h12345678, 32'h00000000, 32'h0000DEAD, 32'h12345678}, // R1 rrmov
    {4'd1, 4'h3, 4'h0, 32'h00000111, 32'h00000000, 32'hABCD0000, 32'hABCD0000}, // R1 irmov
    {4'd1, 4'h4, 4'h0, 32'h00000009, 32'h00000100, 32'h00000020, 32'h00000120}, // R1 store
    {4'd1, 4'h5, 4'h0, 32'h00000009, 32'h00000200, 32'hFFFFFFFC, 32'h000001FC}, // R1 load
    {4'd2, 4'h8, 4'h0, 32'h00000001, 32'h00001000, 32'h00000002, 32'h00000FFC}, // R2 call
    {4'd2, 4'hA, 4'h0, 32'h00000001, 32'h00000000, 32'h00000002, 32'hFFFFFFFC}, // R2 push
    {4'd2, 4'h9, 4'h0, 32'h00000001, 32'h00000FFC, 32'h00000002, 32'h00001000}, // R2 ret
    {4'd2, 4'hB, 4'h0, 32'h00000001, 32'hFFFFFFFE, 32'h00000002, 32'h00000002}, // R2 pop
    {4'd3, 4'h6, 4'h0, 32'h00000003, 32'h00000010, 32'h00000077, 32'h00000013}, // R3 add
    {4'd3, 4'h6, 4'h1, 32'h00000003, 32'h00000010, 32'h00000077, 32'h0000000D}, // R3 sub B-A
    {4'd3, 4'h6, 4'h2, 32'h0000F0F0, 32'h0000FF00, 32'h00000077, 32'h0000F000}, // R3 and
    {4'd3, 4'h6, 4'h3, 32'h0000F0F0, 32'h0000FF00, 32'h00000077, 32'h00000FF0}, // R3 xor
    {4'd3, 4'h6, 4'h5, 32'h00000002, 32'h0000000A, 32'h00000077, 32'h00000008}, // R3 ifun 5 -> sub
    {4'd3, 4'h2, 4'h3, 32'h00000005, 32'h00000000, 32'h00000077, 32'h00000005}, // R3 ifun ignored
    {4'd4, 4'h7, 4'h1, 32'h00000005, 32'h00000040, 32'h00000099, 32'h00000040}, // R4 jump
    {4'd4, 4'h1, 4'h0, 32'h00000001, 32'h00000007, 32'h00000002, 32'h00000007}, // R4 nop
    {4'd4, 4'h0, 4'h0, 32'h00000003, 32'h00000000, 32'h00000002, 32'h00000000}, // R4 halt
    {4'd4, 4'hF, 4'h0, 32'h00000001, 32'h00000002, 32'h00000003, 32'h00000002}  // R4 undefined class
  };

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] ic, logic [3:0] fn, logic [31:0] a,
                       logic [31:0] b, logic [31:0] c);
    @(negedge clk);
    icode = ic; ifun = fn; val_a = a; val_b = b; val_c = c;
    #1;
  endtask

  // Arithmetic op: check result, then let it load the flags
  task automatic arith(logic [3:0] fn, logic [31:0] a, logic [31:0] b,
                       logic [31:0] exp, string req);
    drive(4'h6, fn, a, b, 32'h0);
    check(req, val_e, exp);
    @(posedge clk);
  endtask

  // Read the condition for ifun without touching the flags (jump class)
  task automatic cond(logic [3:0] fn, logic exp, string req);
    drive(4'h7, fn, 32'h0, 32'h0, 32'h0);
    check(req, {31'b0, cnd}, {31'b0, exp});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    icode = 4'h7; ifun = 4'h0; val_a = '0; val_b = '0; val_c = '0;

    // R9 reset values: Z=1 S=0 O=0
    cond(4'd3, 1'b1, "R9 eq in reset");
    cond(4'd2, 1'b0, "R9 lt in reset");
    cond(4'd1, 1'b1, "R9 le in reset");
    cond(4'd6, 1'b0, "R9 gt in reset");

    // R9 release timing: xor 1^0 = 1 would clear Z once a load happens
    drive(4'h6, 4'h3, 32'h1, 32'h0, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    check("R9 no load edge 1", {31'b0, cnd}, 32'h1);
    @(posedge clk); @(negedge clk); #1;
    check("R9 no load edge 2", {31'b0, cnd}, 32'h1);
    @(posedge clk); @(negedge clk); #1;
    check("R9 load edge 3", {31'b0, cnd}, 32'h0);

    // R1 R2 R3 R4 table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][135:132], VECS[i][131:128], VECS[i][127:96],
            VECS[i][95:64], VECS[i][63:32]);
      n_run++;
      if (val_e !== VECS[i][31:0]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual %h expected %h",
                 VECS[i][139:136], i, val_e, VECS[i][31:0]);
      end
    end

    // R6 zero result via subtract
    arith(4'h1, 32'd5, 32'd5, 32'h0, "R3 sub to zero");
    cond(4'd3, 1'b1, "R6 eq after zero");
    cond(4'd1, 1'b1, "R8 le after zero");
    cond(4'd6, 1'b0, "R8 gt after zero");
    cond(4'd4, 1'b0, "R8 ne after zero");

    // R7 add overflow: 7fffffff + 1
    arith(4'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, "R3 add wrap");
    cond(4'd2, 1'b0, "R7 lt after add overflow");
    cond(4'd5, 1'b1, "R7 ge after add overflow");
    cond(4'd6, 1'b1, "R7 gt after add overflow");
    cond(4'd4, 1'b1, "R6 ne after nonzero");

    // R6 negative result without overflow: 0 - 1
    arith(4'h1, 32'h1, 32'h0, 32'hFFFFFFFF, "R3 sub negative");
    cond(4'd2, 1'b1, "R6 lt after negative");
    cond(4'd5, 1'b0, "R8 ge after negative");

    // R7 subtract overflow: 80000000 - 1
    arith(4'h1, 32'h1, 32'h80000000, 32'h7FFFFFFF, "R3 sub wrap");
    cond(4'd2, 1'b1, "R7 lt after sub overflow");
    cond(4'd6, 1'b0, "R7 gt after sub overflow");

    // R7 AND clears overflow: sign set, lt must be 1 only if O cleared
    arith(4'h2, 32'hFFFFFFFF, 32'h80000000, 32'h80000000, "R3 and");
    cond(4'd2, 1'b1, "R7 overflow cleared by and");

    // R5 non-arithmetic classes leave flags alone
    drive(4'h3, 4'h0, 32'h0, 32'h0, 32'h0);
    @(posedge clk);
    drive(4'h2, 4'h3, 32'h0, 32'h0, 32'h0);
    @(posedge clk);
    cond(4'd3, 1'b0, "R5 eq held");
    cond(4'd2, 1'b1, "R5 lt held");

    // R8 always and undefined encodings
    cond(4'd0, 1'b1, "R8 always");
    cond(4'd7, 1'b0, "R8 ifun 7");
    cond(4'd15, 1'b0, "R8 ifun 15");

    // R9 asynchronous assertion mid-cycle
    drive(4'h7, 4'h3, 32'h0, 32'h0, 32'h0);
    check("R9 eq before reset", {31'b0, cnd}, 32'h0);
    rst_n = 1'b0;
    #0.5;
    check("R9 async clear", {31'b0, cnd}, 32'h1);
    drive(4'h7, 4'h2, 32'h0, 32'h0, 32'h0);
    check("R9 lt after async clear", {31'b0, cnd}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    done = 1;
    report();
  end

endmodule